// File: doc/BRIEF.md
# Reset-Strapped Test-Point Multiplexer

This block drives an eight-pin observation port used for calibration and debug. While the power-sense signal is low, the chip is held in reset and the port does not drive. The pad input paths of the four mode pins then carry a strap value set by the board: a pull-down on each pin gives zero, and a fitted pull-up gives one. When power-sense rises, the block synchronizes that edge, captures the four strap bits once as the test mode, and then enables all eight pin drivers.

From then until the next reset, the captured mode picks what the pins show. One mode shows a set of display-timing and colour-wheel strobes. Another passes a processor debug bus straight through. Every other mode, including the all-zero default, holds the pins low so that they do not toggle. Later changes on the strap pins have no effect until reset is applied and released again.

Top module: `tpmux_top`

## Requirements
- R1: Once power-sense has been low for three rising clock edges, `pad_oe` and `pad_out` are all zero. They stay zero for as long as power-sense remains low.
- R2: The mode is the value on `strap_in[3:0]` when power-sense rises, with the strap held steady through the release.
- R3: Changes on `strap_in` after release do not change the pin behaviour until the next reset and release.
- R4: Mode 0x0, the value captured with no pull-ups fitted, drives all eight `pad_out` bits low while `pad_oe` is all ones.
- R5: In mode 0x8, pins 0 to 7 carry, in that order: `cal_vsync`, `cal_cw_idx_dly`, `cal_seq_idx`, `cal_spoke`, `cal_rev`, `cal_rst_aux[0]`, `cal_rst_aux[1]` and `cal_rst_aux[2]`.
- R6: In mode 0x1, `pad_out[n]` carries `dbg_bus[n]` for every n.
- R7: Every mode other than 0x1 and 0x8 (for example 0x3 or 0xF) drives all `pad_out` bits low.
- R8: After power-sense rises ahead of a clock edge, `pad_oe` stays zero through the first three rising edges. It becomes all ones after the fourth.
- R9: `pad_out` follows the selected inputs with a latency of exactly one clock: a change is not visible before the next rising edge, and it is visible after it.
- R10: A second reset and release captures a new strap value, and the pins follow the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_sense | input | 1 | Power-sense / reset release, high = released, asynchronous |
| strap_in | input | 4 | Pad input path of the four mode pins |
| cal_vsync | input | 1 | Vertical sync strobe |
| cal_cw_idx_dly | input | 1 | Delayed colour-wheel index |
| cal_seq_idx | input | 1 | Sequence index |
| cal_spoke | input | 1 | Wheel spoke strobe |
| cal_rev | input | 1 | Wheel revolution strobe |
| cal_rst_aux | input | 3 | Reset-sequence auxiliary bits |
| dbg_bus | input | 8 | Processor debug bus |
| pad_out | output | 8 | Pin drive values |
| pad_oe | output | 8 | Per-pin output enables, 1 = drive |

## Verification
A wrong captured mode shows at the ports on the fourth edge after release, when the drivers turn on. The pins then show the wrong source group, or they stay low when a source group is expected. A fault in the release synchronizer or the capture pulse moves the edge on which `pad_oe` rises, or lets the strap be read again after release. The bench therefore checks the enables on each of the first four edges, and it changes the straps after capture. A swapped or stuck routing bit shows one clock after the affected input changes, so each source bit is toggled on its own pattern and checked at one-edge latency.

// File: rtl/tpmux_pkg.sv
// Package: shared widths, mode codes and the calibration strobe group.
// Assumes the port is eight pins wide and the mode uses four strap bits.
package tpmux_pkg;
    localparam int PORT_W = 8;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_QUIET = 4'h0;
    localparam logic [MODE_W-1:0] MODE_DBG   = 4'h1;
    localparam logic [MODE_W-1:0] MODE_CAL   = 4'h8;

    // Packed so that vsync lands on bit 0 and rst_aux[2] lands on bit 7.
    typedef struct packed {
        logic [2:0] rst_aux;
        logic       rev;
        logic       spoke;
        logic       seq_idx;
        logic       cw_idx_dly;
        logic       vsync;
    } cal_grp_t;
endpackage

// File: rtl/tpmux_sync.sv
// Module: synchronizes the asynchronous power-sense input into the clock
// domain and gives a one-cycle pulse on its rising edge.
// Assumes STAGES >= 2. The synchronized level is the block's active-low reset.
module tpmux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic rel_n,
    output logic cap_pulse
);
    logic [STAGES-1:0] chain;
    logic              rel_d;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], async_in};
    end

    assign rel_n = chain[STAGES-1];

    // Delayed copy of the synchronized level for edge detection (sync reset).
    always_ff @(posedge clk) begin
        if (!rel_n) rel_d <= 1'b0;
        else        rel_d <= 1'b1;
    end

    assign cap_pulse = rel_n & ~rel_d;

    // R8: the capture pulse lasts exactly one cycle after each release.
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rel_n)
        cap_pulse |=> !cap_pulse);
endmodule

// File: rtl/tpmux_strap.sv
// Module: samples the strap pins while reset is held and latches them as the
// test mode on the capture pulse. The mode holds until reset.
// Assumes cap_pulse comes from tpmux_sync and is high one cycle per release.
module tpmux_strap
    import tpmux_pkg::*;
(
    input  logic              clk,
    input  logic              rel_n,
    input  logic              cap_pulse,
    input  logic [MODE_W-1:0] strap_in,
    output logic [MODE_W-1:0] mode,
    output logic              mode_valid
);
    logic [MODE_W-1:0] strap_q;

    // Track the strap pins while in reset; latch the mode once on release.
    always_ff @(posedge clk) begin
        if (!rel_n) begin
            strap_q    <= strap_in;
            mode       <= MODE_QUIET;
            mode_valid <= 1'b0;
        end else if (cap_pulse) begin
            mode       <= strap_q;
            mode_valid <= 1'b1;
        end
    end

    // R2: the mode taken on release is the last strap value seen in reset.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rel_n)
        cap_pulse |=> (mode == $past(strap_q)) && mode_valid);

    // R3: once valid, the mode never changes until reset.
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rel_n)
        (mode_valid && $past(mode_valid)) |-> $stable(mode));
endmodule

// File: rtl/tpmux_route.sv
// Module: picks the source group for the captured mode and registers the pin
// data and the per-pin output enables.
// Assumes mode is stable while mode_valid is high; undefined modes drive low.
module tpmux_route
    import tpmux_pkg::*;
(
    input  logic              clk,
    input  logic              rel_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              mode_valid,
    input  cal_grp_t          cal,
    input  logic [PORT_W-1:0] dbg,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    logic [PORT_W-1:0] sel;

    // Choose the source word for the current mode.
    always_comb begin
        case (mode)
            MODE_CAL: sel = cal;
            MODE_DBG: sel = dbg;
            default:  sel = '0;
        endcase
    end

    // One data and one enable flop per pin, cleared in reset.
    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rel_n) begin
                pad_out[p] <= 1'b0;
                pad_oe[p]  <= 1'b0;
            end else begin
                pad_out[p] <= sel[p];
                pad_oe[p]  <= mode_valid;
            end
        end
    end

    // R1: a driving pin implies a captured mode.
    always_comb begin
        p_oe_needs_mode_r1: assert (pad_oe == '0 || mode_valid);
    end

    // R8: enables rise only after the mode was already valid.
    p_oe_after_mode_r8: assert property (@(posedge clk) disable iff (!rel_n)
        $rose(pad_oe[0]) |-> $past(mode_valid));

    // R7: undefined modes keep the pins low.
    p_undef_low_r7: assert property (@(posedge clk) disable iff (!rel_n)
        (mode != MODE_CAL && mode != MODE_DBG) |=> pad_out == '0);

    // R6: debug mode passes the bus with one clock of latency.
    p_dbg_pass_r6: assert property (@(posedge clk) disable iff (!rel_n)
        (mode == MODE_DBG) |=> pad_out == $past(dbg));
endmodule

// File: rtl/tpmux_top.sv
// Module: reset-strapped test-point multiplexer top level.
// Assumes pwr_sense is asynchronous and is the block's only reset source.
module tpmux_top
    import tpmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              pwr_sense,
    input  logic [MODE_W-1:0] strap_in,
    input  logic              cal_vsync,
    input  logic              cal_cw_idx_dly,
    input  logic              cal_seq_idx,
    input  logic              cal_spoke,
    input  logic              cal_rev,
    input  logic [2:0]        cal_rst_aux,
    input  logic [PORT_W-1:0] dbg_bus,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    logic              rel_n;
    logic              cap_pulse;
    logic [MODE_W-1:0] mode;
    logic              mode_valid;
    cal_grp_t          cal;

    assign cal = '{rst_aux: cal_rst_aux, rev: cal_rev, spoke: cal_spoke,
                   seq_idx: cal_seq_idx, cw_idx_dly: cal_cw_idx_dly,
                   vsync: cal_vsync};

    tpmux_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .async_in  (pwr_sense),
        .rel_n     (rel_n),
        .cap_pulse (cap_pulse)
    );

    tpmux_strap u_strap (
        .clk        (clk),
        .rel_n      (rel_n),
        .cap_pulse  (cap_pulse),
        .strap_in   (strap_in),
        .mode       (mode),
        .mode_valid (mode_valid)
    );

    tpmux_route u_route (
        .clk        (clk),
        .rel_n      (rel_n),
        .mode       (mode),
        .mode_valid (mode_valid),
        .cal        (cal),
        .dbg        (dbg_bus),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );
endmodule

// File: tb/tpmux_top_tb.sv
module tpmux_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       pwr_sense = 1'b0;
    logic [3:0] strap_in = 4'h0;
    logic       cal_vsync = 0, cal_cw_idx_dly = 0, cal_seq_idx = 0;
    logic       cal_spoke = 0, cal_rev = 0;
    logic [2:0] cal_rst_aux = 3'h0;
    logic [7:0] dbg_bus = 8'h00;
    logic [7:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpmux_top u_dut (
        .clk(clk), .pwr_sense(pwr_sense), .strap_in(strap_in),
        .cal_vsync(cal_vsync), .cal_cw_idx_dly(cal_cw_idx_dly),
        .cal_seq_idx(cal_seq_idx), .cal_spoke(cal_spoke), .cal_rev(cal_rev),
        .cal_rst_aux(cal_rst_aux), .dbg_bus(dbg_bus),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Wait for the next rising edge, then sample at the falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive the calibration group from a packed word, bit 0 = vsync.
    task automatic set_cal(input logic [7:0] w);
        {cal_rst_aux, cal_rev, cal_spoke, cal_seq_idx, cal_cw_idx_dly, cal_vsync} = w;
    endtask

    // Hold reset with a strap value, then release and check enable timing.
    task automatic do_release(input logic [3:0] strap);
        @(negedge clk);
        pwr_sense = 1'b0;
        strap_in  = strap;
        step(6);
        check8("R1 oe in reset", pad_oe, 8'h00);
        check8("R1 out in reset", pad_out, 8'h00);
        pwr_sense = 1'b1;
        for (int e = 1; e <= 3; e++) begin
            step(1);
            check8($sformatf("R8 oe after edge %0d", e), pad_oe, 8'h00);
        end
        step(1);
        check8("R8 oe after edge 4", pad_oe, 8'hFF);
    endtask

    task automatic t_reset_state;
        step(4);
        check8("R1 reset oe", pad_oe, 8'h00);
        check8("R1 reset out", pad_out, 8'h00);
    endtask

    task automatic t_quiet;
        do_release(4'h0);
        dbg_bus = 8'hFF; set_cal(8'hFF);
        step(2);
        check8("R4 mode 0 low", pad_out, 8'h00);
        check8("R4 mode 0 oe", pad_oe, 8'hFF);
    endtask

    task automatic t_cal;
        logic [7:0] pats [4] = '{8'h01, 8'h80, 8'h5A, 8'hA5};
        do_release(4'h8);
        dbg_bus = 8'h3C;
        foreach (pats[i]) begin
            set_cal(pats[i]);
            #1;
            check8("R9 not before edge", pad_out, (i == 0) ? 8'hFF : pats[i-1]);
            step(1);
            check8("R5 cal map", pad_out, pats[i]);
        end
        for (int b = 0; b < 8; b++) begin
            set_cal(8'h01 << b);
            step(1);
            check8($sformatf("R5 cal pin %0d", b), pad_out, 8'h01 << b);
        end
    endtask

    task automatic t_dbg;
        do_release(4'h1);
        set_cal(8'hFF);
        for (int b = 0; b < 8; b++) begin
            dbg_bus = ~(8'h01 << b);
            step(1);
            check8($sformatf("R6 dbg pin %0d", b), pad_out, ~(8'h01 << b));
        end
        dbg_bus = 8'hC3;
        #1;
        check8("R9 dbg latency hold", pad_out, 8'h7F);
        step(1);
        check8("R9 dbg latency", pad_out, 8'hC3);
    endtask

    task automatic t_undef(input logic [3:0] m);
        do_release(m);
        dbg_bus = 8'hFF; set_cal(8'hFF);
        step(2);
        check8($sformatf("R7 mode %h low", m), pad_out, 8'h00);
    endtask

    task automatic t_strap_change;
        do_release(4'h1);
        strap_in = 4'h8;
        dbg_bus = 8'h96; set_cal(8'h69);
        step(5);
        check8("R3 strap ignored", pad_out, 8'h96);
        strap_in = 4'h0;
        step(3);
        check8("R3 strap ignored 2", pad_out, 8'h96);
    endtask

    task automatic t_rerelease;
        do_release(4'h8);
        dbg_bus = 8'h11; set_cal(8'h22);
        step(2);
        check8("R10 first mode", pad_out, 8'h22);
        @(negedge clk);
        pwr_sense = 1'b0;
        step(3);
        check8("R1 oe off after 3 edges", pad_oe, 8'h00);
        check8("R1 out off after 3 edges", pad_out, 8'h00);
        do_release(4'h1);
        step(1);
        check8("R10 new mode", pad_out, 8'h11);
    endtask

    initial begin
        t_reset_state();
        t_quiet();
        t_cal();
        t_dbg();
        t_undef(4'h3);
        t_undef(4'hF);
        t_strap_change();
        t_rerelease();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule